// File: doc/BRIEF.md
# Operand Register Bank with Constant Source

This block is the sixteen-entry, 16-bit register bank of a small load/store-style core. It has two combinational operand read ports and one synchronous write port, and it gives special treatment to the low four indices. Slot 0 holds the program counter and slot 1 holds the stack pointer. Both stay word-aligned because bit 0 is cleared on every write. Slot 2 is the status word. Slot 3 has no storage at all.

Each read port takes a 2-bit source mode beside the register index. For slots 2 and 3 the mode picks a hard-wired constant in place of the stored value, so a small immediate costs no extension word. When slot 2 is read with mode 01, the port returns zero and raises an absolute-addressing strobe for the datapath. The ALU updates the four condition flags through a separate per-flag masked port, so it does not need a full write of the status word.

Top module: `opnd_regbank`

## Requirements
- R1: A write to any of indices 4 to 15 stores the full 16-bit value. The value appears on the read ports only after the clock edge that performs the write; during the write cycle the old value is still read.
- R2: A write to index 0 or index 1 stores the value with bit 0 forced to zero.
- R3: A read of index 2 returns the stored status word with mode 00, 0004h with mode 10 and 0008h with mode 11.
- R4: A read of index 2 with mode 01 returns 0000h and drives that port's absolute strobe high. In every other case the strobe is low.
- R5: A read of index 3 returns 0000h, 0001h, 0002h or FFFFh for modes 00, 01, 10 and 11.
- R6: The flag port has a 4-bit enable mask and a 4-bit value, with bit 0 = carry, bit 1 = zero, bit 2 = negative and bit 3 = overflow. These flags live at status bits 0, 1, 2 and 8. Each enabled flag takes its value at the clock edge, and every other status bit keeps its value.
- R7: When a full write to index 2 and a flag update happen in the same cycle, the status word takes the full write value and the flag update is dropped.
- R8: A write to index 3 has no effect, and reads of index 3 still return the mode constants.
- R9: While reset is asserted, every register reads as 0000h, including the program counter.
- R10: For indices other than 2 and 3, the mode input has no effect on the value read.
- R11: The two read ports work independently and can read any two indices, or the same index, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_mode | input | 2 | Read port A source mode |
| rd_a_data | output | 16 | Read port A operand |
| rd_a_abs | output | 1 | Read port A absolute-addressing strobe |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_mode | input | 2 | Read port B source mode |
| rd_b_data | output | 16 | Read port B operand |
| rd_b_abs | output | 1 | Read port B absolute-addressing strobe |
| wr_en | input | 1 | Full register write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write value |
| flg_we | input | 4 | Per-flag update enable {V,N,Z,C} |
| flg_val | input | 4 | Per-flag new value {V,N,Z,C} |

## Verification
Random cycles mix writes to every index, including slot 3, with random flag masks, modes and read indices. This shows stored slots apart from constant slots, and mode-sensitive reads apart from mode-blind ones. Writes often hit the index being read in the same cycle, which exposes any write-through path. Odd values are written to slots 0 and 1 to check the alignment. Directed cycles set up a full status write colliding with a flag update, a flag update with a partial mask, and reads during reset. These tell the write priority apart from a merge, and masked flag bits apart from bits left alone.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int DW   = 16;
  localparam int NREG = 16;
  localparam int IDXW = $clog2(NREG);

  localparam int SLOT_PC = 0;
  localparam int SLOT_SP = 1;
  localparam int SLOT_SR = 2;
  localparam int SLOT_CG = 3;

  // status bit positions of the four flags
  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_N = 2;
  localparam int FB_V = 8;

  typedef enum logic [1:0] {
    SRC_REG  = 2'b00,
    SRC_IDX  = 2'b01,
    SRC_IND  = 2'b10,
    SRC_POST = 2'b11
  } src_mode_e;

  // constant sourced from slot 3
  function automatic logic [DW-1:0] cg3_value(input src_mode_e m);
    logic [DW-1:0] v;
    case (m)
      SRC_REG:  v = '0;
      SRC_IDX:  v = DW'(1);
      SRC_IND:  v = DW'(2);
      default:  v = '1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/opnd_cell.sv
module opnd_cell #(
  parameter int DW    = 16,
  parameter bit ALIGN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] KEEP = ALIGN ? ~DW'(1) : '1;

  logic [DW-1:0] q_r, q_nxt, d_m;

  generate
    if (ALIGN) begin : g_align
      assign d_m = {d[DW-1:1], 1'b0};
    end else begin : g_plain
      assign d_m = d;
    end
  endgenerate

  always_comb begin
    q_nxt = q_r;
    if (we) q_nxt = d_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  AST_CELL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == ($past(d) & KEEP)));  // R1
  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));  // R1
  if (ALIGN) begin : g_chk
    AST_CELL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !q[0]);  // R2
  end
endmodule

// File: rtl/opnd_status.sv
module opnd_status
  import opnd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_we,
  input  logic [DW-1:0] full_d,
  input  logic [3:0]    flg_we,
  input  logic [3:0]    flg_val,
  output logic [DW-1:0] q
);
  logic [DW-1:0] sr_r, sr_nxt;

  always_comb begin
    sr_nxt = sr_r;
    if (full_we) begin
      sr_nxt = full_d;
    end else begin
      if (flg_we[0]) sr_nxt[FB_C] = flg_val[0];
      if (flg_we[1]) sr_nxt[FB_Z] = flg_val[1];
      if (flg_we[2]) sr_nxt[FB_N] = flg_val[2];
      if (flg_we[3]) sr_nxt[FB_V] = flg_val[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_r <= '0;
    else        sr_r <= sr_nxt;
  end

  assign q = sr_r;

  AST_SR_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    full_we |=> (q == $past(full_d)));  // R7
  AST_SR_CARRY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_we && flg_we[0]) |=> (q[FB_C] == $past(flg_val[0])));  // R6
  AST_SR_OVF_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_we && flg_we[3]) |=> (q[FB_V] == $past(flg_val[3])));  // R6
  AST_SR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_we && flg_we == 4'b0) |=> $stable(q));  // R6
endmodule

// File: rtl/opnd_rdport.sv
module opnd_rdport
  import opnd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0][DW-1:0] bank,
  input  logic [IDXW-1:0]         idx,
  input  logic [1:0]              mode,
  output logic [DW-1:0]           data,
  output logic                    abs_sel
);
  src_mode_e m;
  assign m = src_mode_e'(mode);

  always_comb begin
    data    = bank[idx];
    abs_sel = 1'b0;
    if (idx == IDXW'(SLOT_CG)) begin
      data = cg3_value(m);
    end else if (idx == IDXW'(SLOT_SR)) begin
      case (m)
        SRC_REG:  data = bank[idx];
        SRC_IDX:  begin data = '0; abs_sel = 1'b1; end
        SRC_IND:  data = DW'(4);
        default:  data = DW'(8);
      endcase
    end
  end
endmodule

// File: rtl/opnd_regbank.sv
module opnd_regbank
  import opnd_pkg::*;
#(
  parameter int W    = DW,
  parameter int N    = NREG,
  parameter int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [1:0]    rd_a_mode,
  output logic [W-1:0]  rd_a_data,
  output logic          rd_a_abs,
  input  logic [IW-1:0] rd_b_idx,
  input  logic [1:0]    rd_b_mode,
  output logic [W-1:0]  rd_b_data,
  output logic          rd_b_abs,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [3:0]    flg_we,
  input  logic [3:0]    flg_val
);
  localparam int NPORT = 2;

  logic [N-1:0][W-1:0] bank;
  logic [N-1:0]        slot_we;

  // write decode
  always_comb begin
    slot_we = '0;
    if (wr_en) slot_we[wr_idx] = 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_slot
      if (gi == SLOT_CG) begin : g_const
        assign bank[gi] = '0;
      end else if (gi == SLOT_SR) begin : g_sr
        opnd_status #(.DW(W)) u_sr (
          .clk(clk), .rst_n(rst_n),
          .full_we(slot_we[gi]), .full_d(wr_data),
          .flg_we(flg_we), .flg_val(flg_val),
          .q(bank[gi])
        );
      end else begin : g_reg
        opnd_cell #(.DW(W), .ALIGN(gi == SLOT_PC || gi == SLOT_SP)) u_cell (
          .clk(clk), .rst_n(rst_n),
          .we(slot_we[gi]), .d(wr_data), .q(bank[gi])
        );
      end
    end
  endgenerate

  logic [NPORT-1:0][IW-1:0] p_idx;
  logic [NPORT-1:0][1:0]    p_mode;
  logic [NPORT-1:0][W-1:0]  p_data;
  logic [NPORT-1:0]         p_abs;

  assign p_idx  = {rd_b_idx, rd_a_idx};
  assign p_mode = {rd_b_mode, rd_a_mode};

  generate
    for (gi = 0; gi < NPORT; gi++) begin : g_port
      opnd_rdport #(.DW(W), .NREG(N), .IDXW(IW)) u_rd (
        .bank(bank), .idx(p_idx[gi]), .mode(p_mode[gi]),
        .data(p_data[gi]), .abs_sel(p_abs[gi])
      );
    end
  endgenerate

  assign rd_a_data = p_data[0];
  assign rd_a_abs  = p_abs[0];
  assign rd_b_data = p_data[1];
  assign rd_b_abs  = p_abs[1];

  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == IW'(SLOT_PC)) |-> !rd_a_data[0]);  // R2
  AST_ABS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_abs |-> (rd_a_data == '0 && rd_a_idx == IW'(SLOT_SR)));  // R4
  AST_CG3_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == IW'(SLOT_CG) && rd_b_mode == 2'b11) |-> (rd_b_data == '1));  // R5
  AST_CG3_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_idx == IW'(SLOT_CG)) && rd_a_idx == IW'(SLOT_CG)
     && rd_a_mode == 2'b00) |-> (rd_a_data == '0));  // R8
endmodule

// File: tb/opnd_regbank_test.sv
`timescale 1ns/1ps
module opnd_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [1:0]  rd_a_mode, rd_b_mode;
  logic [15:0] rd_a_data, rd_b_data, wr_data;
  logic        rd_a_abs, rd_b_abs, wr_en;
  logic [3:0]  flg_we, flg_val;

  always #4 clk = ~clk;  // 125 MHz

  opnd_regbank uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_data(rd_a_data), .rd_a_abs(rd_a_abs),
    .rd_b_idx(rd_b_idx), .rd_b_mode(rd_b_mode), .rd_b_data(rd_b_data), .rd_b_abs(rd_b_abs),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .flg_we(flg_we), .flg_val(flg_val)
  );

  logic [15:0] m [16];
  int n_run = 0;
  int n_fail = 0;

  function automatic logic [15:0] exp_rd(input logic [3:0] i, input logic [1:0] md);
    if (i == 4'd3) begin
      case (md)
        2'b00: return 16'h0000;
        2'b01: return 16'h0001;
        2'b10: return 16'h0002;
        default: return 16'hFFFF;
      endcase
    end
    if (i == 4'd2) begin
      case (md)
        2'b00: return m[2];
        2'b01: return 16'h0000;
        2'b10: return 16'h0004;
        default: return 16'h0008;
      endcase
    end
    return m[i];  // R10: mode ignored here
  endfunction

  function automatic string tag_of(input logic [3:0] i, input logic [1:0] md);
    if (i <= 4'd1) return "R2";
    if (i == 4'd2) return (md == 2'b01) ? "R4" : "R3";
    if (i == 4'd3) return "R5";
    return (md != 2'b00) ? "R10" : "R1";
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_ports();
    chk(tag_of(rd_a_idx, rd_a_mode), rd_a_data, exp_rd(rd_a_idx, rd_a_mode));
    chk("R4", {15'b0, rd_a_abs}, {15'b0, (rd_a_idx == 4'd2 && rd_a_mode == 2'b01)});
    chk("R11", rd_b_data, exp_rd(rd_b_idx, rd_b_mode));
    chk("R11", {15'b0, rd_b_abs}, {15'b0, (rd_b_idx == 4'd2 && rd_b_mode == 2'b01)});
  endtask

  task automatic model_update();
    if (wr_en && wr_idx != 4'd3) begin
      m[wr_idx] = wr_data;
      if (wr_idx <= 4'd1) m[wr_idx][0] = 1'b0;
    end
    if (!(wr_en && wr_idx == 4'd2)) begin  // R7: full write wins
      if (flg_we[0]) m[2][0] = flg_val[0];
      if (flg_we[1]) m[2][1] = flg_val[1];
      if (flg_we[2]) m[2][2] = flg_val[2];
      if (flg_we[3]) m[2][8] = flg_val[3];
    end
  endtask

  // inputs already set after a falling edge
  task automatic step();
    #1;
    check_ports();
    model_update();
    @(posedge clk);
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_idx = 0; wr_data = 0; flg_we = 0; flg_val = 0;
    rd_a_idx = 0; rd_a_mode = 0; rd_b_idx = 0; rd_b_mode = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0430));
    rst_n = 0;
    idle_inputs();
    for (int i = 0; i < 16; i++) m[i] = 16'h0;
    repeat (3) @(posedge clk);
    // R9: every slot reads zero under reset
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i);
      #1 chk("R9", rd_a_data, 16'h0000);
    end
    @(negedge clk); rst_n = 1;

    // R2: odd values into PC and SP
    @(negedge clk); wr_en = 1; wr_idx = 0; wr_data = 16'hABCD; step();
    @(negedge clk); wr_idx = 1; wr_data = 16'h1235; rd_a_idx = 0; step();
    @(negedge clk); wr_en = 0; rd_a_idx = 1; #1 chk("R2", rd_a_data, 16'h1234); step();

    // R8: write to slot 3 ignored
    @(negedge clk); wr_en = 1; wr_idx = 3; wr_data = 16'h5A5A; step();
    @(negedge clk); wr_en = 0; rd_a_idx = 3; rd_a_mode = 0; rd_b_idx = 3; rd_b_mode = 2'b01;
    #1 chk("R8", rd_a_data, 16'h0000); chk("R8", rd_b_data, 16'h0001); step();

    // R1: no write-through in the write cycle
    @(negedge clk); wr_en = 1; wr_idx = 7; wr_data = 16'hBEEF; rd_a_idx = 7; rd_a_mode = 0;
    #1 chk("R1", rd_a_data, 16'h0000); step();
    @(negedge clk); wr_en = 0; #1 chk("R1", rd_a_data, 16'hBEEF); step();

    // R6: masked flag update, status starts at zero
    @(negedge clk); flg_we = 4'b1010; flg_val = 4'b1111; rd_a_idx = 2; rd_a_mode = 0; step();
    @(negedge clk); flg_we = 4'b0001; flg_val = 4'b0000;
    #1 chk("R6", rd_a_data, 16'h0102); step();
    @(negedge clk); flg_we = 0; #1 chk("R6", rd_a_data, 16'h0102); step();

    // R7: full write collides with flag update
    @(negedge clk); wr_en = 1; wr_idx = 2; wr_data = 16'h00F0; flg_we = 4'b1111; flg_val = 4'b1111; step();
    @(negedge clk); wr_en = 0; flg_we = 0; #1 chk("R7", rd_a_data, 16'h00F0); step();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      wr_en     = ($urandom_range(0, 3) != 0);
      wr_idx    = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 3)) : 4'($urandom);
      wr_data   = 16'($urandom);
      flg_we    = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0;
      flg_val   = 4'($urandom);
      rd_a_idx  = ($urandom_range(0, 1) == 0) ? wr_idx : 4'($urandom);
      rd_a_mode = 2'($urandom);
      rd_b_idx  = ($urandom_range(0, 2) == 0) ? rd_a_idx : 4'($urandom);
      rd_b_mode = 2'($urandom);
      step();
    end

    @(negedge clk);
    finish_run();
  end
endmodule